// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block lays a 64x64 pixel cursor sprite over a raster pixel stream. The sprite pattern sits in a small local RAM that is written through a 64-bit write port, two words per sprite row. Each sprite pixel is a 2-bit code: it picks one of two programmable colours, lets the underlying raster pixel through unchanged, or replaces it with the bitwise inverse of that pixel.

The raster source presents one pixel per cycle along with its screen coordinates. The block compares those coordinates with a programmed cursor position. Horizontal and vertical presets drop leading columns and rows of the sprite, so a cursor that is partly off the top or left edge is shown by clamping the position to zero and raising the presets. Position and presets are taken into shadow registers only on a frame-start pulse, so a frame never shows a half-updated cursor. A control bit turns the overlay on or off without any frame synchronisation.

Top module: `cursor_sprite`

## Requirements
- R1: The pattern RAM holds 128 words of 64 bits. A write to address `pat_addr` = row*2 + half stores `pat_wdata`. Half 0 holds sprite columns 0..31 and half 1 holds columns 32..63. Column c of a half sits in bits [2*(c mod 32)+1 : 2*(c mod 32)], so the leftmost pixel of each byte uses its least significant bit pair.
- R2: Code 00 outputs `clr0`, code 01 outputs `clr1`, code 10 outputs `pix_in` unchanged, and code 11 outputs `~pix_in`.
- R3: `gen_ctrl[7]` is the overlay enable. While it is clear, `pix_out` equals `pix_in`, whatever the other `gen_ctrl` bits are.
- R4: `pos_in` carries cursor y in bits 31:16 and cursor x in bits 15:0. With zero presets, raster pixel (x+c, y+r) for 0<=c,r<=63 shows sprite pixel (c, r). Every pixel outside that square passes through.
- R5: `preset_in` carries the vertical preset in bits 31:16 and the horizontal preset in bits 15:0. Raster pixel (x+c, y+r) shows sprite pixel (c+hpreset, r+vpreset). The cursor is visible only for c < 64-hpreset and r < 64-vpreset.
- R6: `pos_in` and `preset_in` are captured only in a cycle with `frame_start` high. They govern pixels presented from the following cycle on, and changes in other cycles have no effect.
- R7: `pix_out` is registered. It reflects the pixel presented one clock cycle earlier.
- R8: While `rst_n` is low, `pix_out` is 0 and the captured position and presets are 0.
- R9: A preset of 64 or more hides the cursor completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern RAM write strobe |
| pat_addr | input | 7 | Pattern word address (row*2 + half) |
| pat_wdata | input | 64 | Pattern word, 32 pixels of 2 bits |
| clr0 | input | PIX_W | Colour for code 00 |
| clr1 | input | PIX_W | Colour for code 01 |
| gen_ctrl | input | 8 | Control byte, bit 7 enables the overlay |
| pos_in | input | 32 | Cursor position {y, x} |
| preset_in | input | 32 | Presets {vertical, horizontal} |
| frame_start | input | 1 | Capture position and presets |
| ras_x | input | 16 | Raster column of `pix_in` |
| ras_y | input | 16 | Raster row of `pix_in` |
| pix_in | input | PIX_W | Underlying raster pixel |
| pix_out | output | PIX_W | Pixel after the cursor overlay |

## Verification
Every overlay result appears on `pix_out` exactly one edge after its pixel and coordinates are presented. The bench drives each pixel on a falling edge and compares on the next falling edge, one registered stage later. A frame-start pulse takes effect for the pixel presented in the next cycle, so the bench always leaves one whole cycle between the pulse and the pixels that test the new position. Pattern RAM writes finish before any pixel that reads them is driven.

// File: rtl/cursor_sprite.sv
module cursor_sprite #(
  parameter int PIX_W  = 24,
  parameter int EN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_we,
  input  logic [6:0]       pat_addr,
  input  logic [63:0]      pat_wdata,
  input  logic [PIX_W-1:0] clr0,
  input  logic [PIX_W-1:0] clr1,
  input  logic [7:0]       gen_ctrl,
  input  logic [31:0]      pos_in,
  input  logic [31:0]      preset_in,
  input  logic             frame_start,
  input  logic [15:0]      ras_x,
  input  logic [15:0]      ras_y,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out
);
  localparam int SIDE  = 64;
  localparam int WORDS = SIDE * 2;

  logic [15:0] cx, cy, hp, vp;
  logic [63:0] pat_mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx <= '0; cy <= '0; hp <= '0; vp <= '0;
    end else if (frame_start) begin
      cx <= pos_in[15:0];
      cy <= pos_in[31:16];
      hp <= preset_in[15:0];
      vp <= preset_in[31:16];
    end
  end

  always_ff @(posedge clk)
    if (pat_we) pat_mem[pat_addr] <= pat_wdata;

  logic [16:0] dcol, drow;
  logic        hit;
  assign dcol = {1'b0, ras_x - cx} + {1'b0, hp};
  assign drow = {1'b0, ras_y - cy} + {1'b0, vp};
  assign hit  = (ras_x >= cx) && (ras_y >= cy) && (dcol < 17'(SIDE)) && (drow < 17'(SIDE));

  logic [63:0] word;
  logic [1:0]  code;
  assign word = pat_mem[{drow[5:0], dcol[5]}];
  assign code = word[{dcol[4:0], 1'b0} +: 2];

  logic [PIX_W-1:0] mixed;
  always_comb begin
    mixed = pix_in;
    if (gen_ctrl[EN_BIT] && hit) begin
      case (code)
        2'b00:   mixed = clr0;
        2'b01:   mixed = clr1;
        2'b10:   mixed = pix_in;
        default: mixed = ~pix_in;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= mixed;
  end
endmodule

module cursor_sprite_chk #(
  parameter int PIX_W  = 24,
  parameter int EN_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       gen_ctrl,
  input logic             frame_start,
  input logic [31:0]      pos_in,
  input logic [31:0]      preset_in,
  input logic [15:0]      ras_x,
  input logic [15:0]      ras_y,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] pix_out,
  input logic [15:0]      cx,
  input logic [15:0]      cy,
  input logic [15:0]      hp,
  input logic [15:0]      vp
);
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ctrl[EN_BIT] |=> pix_out == $past(pix_in));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ({cy, cx} == $past(pos_in)) && ({vp, hp} == $past(preset_in)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cx) && $stable(cy) && $stable(hp) && $stable(vp));

  assert_left_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_x < cx) |=> pix_out == $past(pix_in));

  assert_above_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_y < cy) |=> pix_out == $past(pix_in));

  assert_hpreset_hide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hp >= 16'd64 && !frame_start) |=> pix_out == $past(pix_in));
endmodule

bind cursor_sprite cursor_sprite_chk #(.PIX_W(PIX_W), .EN_BIT(EN_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .gen_ctrl(gen_ctrl), .frame_start(frame_start),
  .pos_in(pos_in), .preset_in(preset_in), .ras_x(ras_x), .ras_y(ras_y),
  .pix_in(pix_in), .pix_out(pix_out), .cx(cx), .cy(cy), .hp(hp), .vp(vp)
);

// File: tb/cursor_sprite_tb_top.sv
module cursor_sprite_tb_top;
  localparam int PIX_W = 24;
  localparam logic [PIX_W-1:0] C0 = 24'h111111;
  localparam logic [PIX_W-1:0] C1 = 24'h222222;
  localparam logic [PIX_W-1:0] PA = 24'hABCDEF;
  localparam logic [PIX_W-1:0] PN = 24'h543210;

  logic clk = 0;
  logic rst_n = 0;
  logic pat_we = 0;
  logic [6:0] pat_addr = '0;
  logic [63:0] pat_wdata = '0;
  logic [7:0] gen_ctrl = 8'h00;
  logic [31:0] pos_in = '0, preset_in = '0;
  logic frame_start = 0;
  logic [15:0] ras_x = '0, ras_y = '0;
  logic [PIX_W-1:0] pix_in = '0;
  logic [PIX_W-1:0] pix_out;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cursor_sprite #(.PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .clr0(C0), .clr1(C1), .gen_ctrl(gen_ctrl),
    .pos_in(pos_in), .preset_in(preset_in), .frame_start(frame_start),
    .ras_x(ras_x), .ras_y(ras_y), .pix_in(pix_in), .pix_out(pix_out)
  );

  // {x, y, pix_in, expected}; cursor at (100,50), zero presets, code = (col+row)&3
  localparam logic [79:0] VEC [12] = '{
    {16'd99,  16'd50,  PA, PA},
    {16'd100, 16'd50,  PA, C0},
    {16'd101, 16'd50,  PA, C1},
    {16'd102, 16'd50,  PA, PA},
    {16'd103, 16'd50,  PA, PN},
    {16'd163, 16'd50,  PA, PN},
    {16'd164, 16'd50,  PA, PA},
    {16'd100, 16'd113, PA, PN},
    {16'd100, 16'd114, PA, PA},
    {16'd100, 16'd49,  PA, PA},
    {16'd131, 16'd70,  24'h00FF00, 24'hFF00FF},
    {16'd132, 16'd51,  PA, C1}
  };

  task automatic check(string tag, logic [PIX_W-1:0] exp);
    total++;
    if (pix_out !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, pix_out, exp);
    end
  endtask

  task automatic px(logic [15:0] x, logic [15:0] y, logic [PIX_W-1:0] p);
    @(negedge clk);
    ras_x = x; ras_y = y; pix_in = p;
    @(negedge clk);
  endtask

  task automatic frame(logic [31:0] pos, logic [31:0] pre);
    @(negedge clk);
    pos_in = pos; preset_in = pre; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 64; r++)
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        pat_we = 1;
        pat_addr = 7'(r * 2 + h);
        for (int p = 0; p < 32; p++)
          pat_wdata[2*p +: 2] = 2'((h * 32 + p + r) & 3);
      end
    @(negedge clk);
    pat_we = 0;
    check("R8 reset output", '0);

    rst_n = 1;
    gen_ctrl = 8'h80;
    px(16'd0, 16'd0, PA);  check("R8 reset position zero col0", C0);
    px(16'd1, 16'd0, PA);  check("R8 R1 reset position col1", C1);

    frame({16'd50, 16'd100}, 32'd0);
    for (int i = 0; i < 12; i++) begin
      px(VEC[i][79:64], VEC[i][63:48], VEC[i][47:24]);
      check($sformatf("R1 R2 R4 R7 vector %0d", i), VEC[i][23:0]);
    end

    frame(32'd0, {16'd2, 16'd3});
    px(16'd0, 16'd0, PA);   check("R5 first shown pixel", C1);
    px(16'd60, 16'd0, PA);  check("R5 last shown column", C1);
    px(16'd61, 16'd0, PA);  check("R5 past last column", PA);
    px(16'd1, 16'd61, PA);  check("R5 last shown row", PN);
    px(16'd1, 16'd62, PA);  check("R5 past last row", PA);

    @(negedge clk);
    pos_in = {16'd200, 16'd200}; preset_in = 32'd0;
    px(16'd0, 16'd0, PA);   check("R6 no capture without pulse", C1);
    frame({16'd200, 16'd200}, 32'd0);
    px(16'd0, 16'd0, PA);   check("R6 old position gone", PA);
    px(16'd200, 16'd200, PA); check("R6 new position", C0);

    gen_ctrl = 8'h7F;
    px(16'd200, 16'd200, PA); check("R3 overlay disabled", PA);
    px(16'd203, 16'd200, PA); check("R3 disabled complement code", PA);
    gen_ctrl = 8'h80;

    frame(32'd0, {16'd0, 16'd64});
    px(16'd0, 16'd0, PA);   check("R9 hpreset 64 hides", PA);
    frame(32'd0, {16'd64, 16'd0});
    px(16'd0, 16'd0, PA);   check("R9 vpreset 64 hides", PA);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule